// File: doc/BRIEF.md
# Five-Channel Timer with Infrared Burst Modulation

This block is a 16-bit up-counter whose rate is set by a clock divider, wrapping at a programmable limit. Five channels watch the count. A channel in compare mode drives a pulse-width output. A channel in capture mode latches the count when its input pin shows a selected edge, and sets a per-channel flag.

In infrared mode the counter stops using the divider. It advances once each time an external 8-bit carrier timer completes a period. Every channel output is then gated by the carrier waveform, so a compare window turns into a burst of carrier pulses.

Software reaches all state through a small word-wide register port. A write takes effect on the clock edge. A read is combinational from the address. Register map (word addresses):

| Address | Contents |
|---|---|
| 0 | control: bit0 run, bits 2:1 divider select, bit3 infrared mode |
| 1 | period limit |
| 2 | count (a write clears it) |
| 3 | flags: bit0 wrap, bit 1+i capture on channel i |
| 4+i | channel i setup: bit0 capture mode, bits 2:1 edge select |
| 9+i | channel i value (compare threshold, or the last captured count) |

Top module: `ir_pwm_timer`

## Requirements
- R1: After reset the count is 0, control is 0, the period limit is 0xFFFF, all flags are 0, all channel values and setups are 0, and every channel output is low.
- R2: With infrared mode off and run set, the count advances once every 1, 8, 32 or 128 clocks for divider select codes 0, 1, 2 and 3 in control bits 2:1.
- R3: A count step taken while the count equals or exceeds the period limit loads 0 and sets the wrap flag (flags bit0).
- R4: A channel in compare mode (setup bit0 = 0) drives its output high exactly while the count is below its value register.
- R5: A channel in capture mode copies the count into its value register and sets flags bit 1+i on a selected edge of its input. Edge select 01 takes rising edges only, 10 falling only, 11 both, and 00 none. The edge is seen on the clock after the pin changes.
- R6: A channel in capture mode drives its output low.
- R7: With infrared mode (control bit3) and run set, the count advances once per clock in which the carrier terminal strobe is high, and the divider select has no effect.
- R8: With infrared mode set, every channel output is the AND of its compare result and the carrier output.
- R9: With run clear, the count holds its value. Any write to address 2 clears the count.
- R10: Flags are cleared by writing 1 to their bit at address 3. A flag that is set and cleared in the same clock stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr |
| cap_in | input | 5 | Per-channel capture input pins |
| carrier_tick | input | 1 | Carrier timer terminal-count strobe |
| carrier_out | input | 1 | Carrier timer waveform |
| ch_out | output | 5 | Per-channel outputs |

## Verification
On every cycle, the assertions check the following:
- a counting step adds exactly one;
- a step at or past the limit returns the count to zero and raises the wrap flag;
- the count is frozen when there is no step and no clear;
- capture-mode channels stay low;
- in infrared mode no output is high while the carrier is low;
- a capture event always leaves its flag set.

Other properties can only be shown by the bench's directed scenarios, because each needs a model of the stimulus:
- the actual division ratio for each select code;
- the exact captured value and which edge polarity is honoured;
- the count reached after a number of carrier periods;
- the precedence of a capture over a simultaneous flag clear.

// File: rtl/ir_pwm_timer.sv
module ir_pwm_timer #(
  parameter int NCH = 5,
  parameter int CW  = 16,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [CW-1:0]  wdata,
  output logic [CW-1:0]  rd_data,
  input  logic [NCH-1:0] cap_in,
  input  logic           carrier_tick,
  input  logic           carrier_out,
  output logic [NCH-1:0] ch_out
);
  localparam int A_CTRL   = 0;
  localparam int A_PERIOD = 1;
  localparam int A_COUNT  = 2;
  localparam int A_FLAGS  = 3;
  localparam int CFG_BASE = 4;
  localparam int VAL_BASE = CFG_BASE + NCH;
  localparam int PW       = 7;

  logic           run, ir_mode;
  logic [1:0]     psel;
  logic [CW-1:0]  period, cnt;
  logic [PW-1:0]  pre_cnt, pre_lim;
  logic           ovf;
  logic [NCH-1:0] cap_flag, cap_d, cap_mode, cap_hit, pwm;
  logic [1:0]     edge_sel [NCH];
  logic [CW-1:0]  chval    [NCH];

  logic wr_ctrl, wr_period, cnt_wr, wr_flags, pre_hit, tick, wrap;

  assign wr_ctrl   = wr_en && addr == AW'(A_CTRL);
  assign wr_period = wr_en && addr == AW'(A_PERIOD);
  assign cnt_wr    = wr_en && addr == AW'(A_COUNT);
  assign wr_flags  = wr_en && addr == AW'(A_FLAGS);

  always_comb begin
    case (psel)
      2'd0:    pre_lim = PW'(0);
      2'd1:    pre_lim = PW'(7);
      2'd2:    pre_lim = PW'(31);
      default: pre_lim = PW'(127);
    endcase
  end

  assign pre_hit = pre_cnt == pre_lim;
  assign tick    = run && (ir_mode ? carrier_tick : pre_hit);
  assign wrap    = tick && cnt >= period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      ir_mode <= 1'b0;
      psel    <= 2'd0;
      period  <= '1;
    end else begin
      if (wr_ctrl) begin
        run     <= wdata[0];
        psel    <= wdata[2:1];
        ir_mode <= wdata[3];
      end
      if (wr_period) period <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   pre_cnt <= '0;
    else if (!run || ir_mode || cnt_wr || pre_hit) pre_cnt <= '0;
    else                                          pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (cnt_wr)  cnt <= '0;
    else if (wrap)    cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ovf <= 1'b0;
    else if (wrap)                  ovf <= 1'b1;
    else if (wr_flags && wdata[0])  ovf <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_d <= '0;
    else        cap_d <= cap_in;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic rise, fall;
    assign rise       = cap_in[i] & ~cap_d[i];
    assign fall       = ~cap_in[i] & cap_d[i];
    assign cap_hit[i] = cap_mode[i] & ((edge_sel[i][0] & rise) | (edge_sel[i][1] & fall));
    assign pwm[i]     = ~cap_mode[i] & (cnt < chval[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_mode[i] <= 1'b0;
        edge_sel[i] <= 2'b00;
      end else if (wr_en && addr == AW'(CFG_BASE + i)) begin
        cap_mode[i] <= wdata[0];
        edge_sel[i] <= wdata[2:1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    chval[i] <= '0;
      else if (cap_hit[i])                           chval[i] <= cnt;
      else if (wr_en && addr == AW'(VAL_BASE + i))   chval[i] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cap_flag[i] <= 1'b0;
      else if (cap_hit[i])               cap_flag[i] <= 1'b1;
      else if (wr_flags && wdata[i+1])   cap_flag[i] <= 1'b0;
    end
  end

  assign ch_out = pwm & {NCH{~ir_mode | carrier_out}};

  always_comb begin
    rd_data = '0;
    case (addr)
      AW'(A_CTRL):   rd_data = CW'({ir_mode, psel, run});
      AW'(A_PERIOD): rd_data = period;
      AW'(A_COUNT):  rd_data = cnt;
      AW'(A_FLAGS):  rd_data = CW'({cap_flag, ovf});
      default:       rd_data = '0;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(CFG_BASE + i)) rd_data = CW'({edge_sel[i], cap_mode[i]});
      if (addr == AW'(VAL_BASE + i)) rd_data = chval[i];
    end
  end
endmodule

module ir_pwm_timer_chk #(
  parameter int NCH = 5,
  parameter int CW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           wrap,
  input logic           cnt_wr,
  input logic [CW-1:0]  cnt,
  input logic           ovf,
  input logic           ir_mode,
  input logic           carrier_out,
  input logic [NCH-1:0] ch_out,
  input logic [NCH-1:0] cap_mode,
  input logic [NCH-1:0] cap_hit,
  input logic [NCH-1:0] cap_flag
);
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap && !cnt_wr) |=> (cnt - $past(cnt)) == CW'(1)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0 && ovf)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt)); // R9
  AST_CAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_out & cap_mode) == '0); // R6
  AST_IR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_mode && !carrier_out) |-> ch_out == '0); // R8
  AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_hit != '0) |=> (cap_flag & $past(cap_hit)) == $past(cap_hit)); // R5
endmodule

bind ir_pwm_timer ir_pwm_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .cnt_wr(cnt_wr),
  .cnt(cnt), .ovf(ovf), .ir_mode(ir_mode), .carrier_out(carrier_out),
  .ch_out(ch_out), .cap_mode(cap_mode), .cap_hit(cap_hit), .cap_flag(cap_flag)
);

// File: tb/ir_pwm_timer_bench.sv
module ir_pwm_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rd_data;
  logic [4:0]  cap_in = '0;
  logic        carrier_tick, carrier_out;
  logic [4:0]  ch_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit win = 0;
  int ir_exp = 0;
  logic [15:0] rdv;

  localparam logic [7:0] CAR_PER = 8'd3;
  localparam logic [7:0] CAR_CMP = 8'd2;
  logic [7:0] car_cnt;

  always #5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                car_cnt <= '0;
    else if (car_cnt == CAR_PER) car_cnt <= '0;
    else                       car_cnt <= car_cnt + 1'b1;
  end
  assign carrier_tick = car_cnt == CAR_PER;
  assign carrier_out  = car_cnt < CAR_CMP;

  always @(posedge clk) if (win && carrier_tick) ir_exp++;

  ir_pwm_timer u_ir_pwm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .cap_in(cap_in), .carrier_tick(carrier_tick),
    .carrier_out(carrier_out), .ch_out(ch_out)
  );

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a);
    addr = a;
    #1 rdv = rd_data;
  endtask

  task automatic run_edges(logic [15:0] ctrl, int e);
    wr(4'd0, ctrl | 16'd1);
    win = 1;
    repeat (e - 1) @(negedge clk);
    wr(4'd0, ctrl & ~16'd1);
    win = 0;
  endtask

  task automatic t_reset();
    rd(4'd0); check("R1 ctrl", rdv, 16'h0000);
    rd(4'd1); check("R1 period", rdv, 16'hFFFF);
    rd(4'd2); check("R1 count", rdv, 16'h0000);
    rd(4'd3); check("R1 flags", rdv, 16'h0000);
    rd(4'd9); check("R1 ch0 value", rdv, 16'h0000);
    check("R1 outputs", {11'b0, ch_out}, 16'h0000);
  endtask

  task automatic t_prescale();
    int divs [4] = '{1, 8, 32, 128};
    for (int s = 0; s < 4; s++) begin
      wr(4'd2, 16'd0);
      run_edges(16'(s << 1), divs[s] * 3 + divs[s] / 2);
      rd(4'd2); check("R2 divider", rdv, 16'd3);
    end
  endtask

  task automatic t_wrap();
    wr(4'd1, 16'd4);
    wr(4'd2, 16'd0);
    run_edges(16'd0, 7);
    rd(4'd2); check("R3 wrapped count", rdv, 16'd2);
    rd(4'd3); check("R3 wrap flag", rdv, 16'h0001);
    repeat (5) @(negedge clk);
    rd(4'd2); check("R9 hold when stopped", rdv, 16'd2);
    wr(4'd3, 16'h0001);
    rd(4'd3); check("R10 wrap flag cleared", rdv, 16'h0000);
    wr(4'd2, 16'h1234);
    rd(4'd2); check("R9 count write clears", rdv, 16'd0);
  endtask

  task automatic t_pwm();
    int pts [4] = '{1, 3, 4, 7};
    wr(4'd1, 16'd9);
    wr(4'd6, 16'd0);
    wr(4'd11, 16'd4);
    wr(4'd12, 16'd0);
    wr(4'd13, 16'hFFFF);
    for (int k = 0; k < 4; k++) begin
      wr(4'd2, 16'd0);
      run_edges(16'd0, pts[k]);
      #1;
      check("R4 compare output ch2", {15'b0, ch_out[2]}, {15'b0, pts[k] < 4});
      check("R4 zero threshold ch3", {15'b0, ch_out[3]}, 16'd0);
      check("R4 full threshold ch4", {15'b0, ch_out[4]}, 16'd1);
    end
  endtask

  task automatic t_capture();
    wr(4'd1, 16'hFFFF);
    wr(4'd5, 16'b011);
    wr(4'd2, 16'd0);
    run_edges(16'd0, 5);
    cap_in[1] = 1'b1; @(negedge clk);
    rd(4'd10); check("R5 rising capture value", rdv, 16'd5);
    rd(4'd3);  check("R5 rising capture flag", rdv, 16'h0004);
    run_edges(16'd0, 1);
    cap_in[1] = 1'b0; @(negedge clk);
    rd(4'd10); check("R5 falling ignored in rising mode", rdv, 16'd5);
    wr(4'd3, 16'h0004);
    rd(4'd3);  check("R10 capture flag cleared", rdv, 16'h0000);
    wr(4'd5, 16'b101);
    cap_in[1] = 1'b1; @(negedge clk);
    rd(4'd10); check("R5 rising ignored in falling mode", rdv, 16'd5);
    rd(4'd3);  check("R5 no flag on ignored edge", rdv, 16'h0000);
    cap_in[1] = 1'b0; @(negedge clk);
    rd(4'd10); check("R5 falling capture value", rdv, 16'd6);
    wr(4'd5, 16'b111);
    run_edges(16'd0, 2);
    cap_in[1] = 1'b1; @(negedge clk);
    rd(4'd10); check("R5 both-edge rise", rdv, 16'd8);
    run_edges(16'd0, 1);
    cap_in[1] = 1'b0; addr = 4'd3; wdata = 16'h0004; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(4'd10); check("R5 both-edge fall", rdv, 16'd9);
    rd(4'd3);  check("R10 set beats clear", rdv, 16'h0004);
    wr(4'd8, 16'b001);
    #1 check("R6 capture channel low", {15'b0, ch_out[4]}, 16'd0);
  endtask

  task automatic t_ir();
    wr(4'd1, 16'hFFFF);
    wr(4'd9, 16'hFFFF);
    wr(4'd2, 16'd0);
    ir_exp = 0;
    run_edges(16'b1110, 40);
    rd(4'd2); check("R7 count of carrier periods", rdv, 16'(ir_exp));
    check("R7 carrier periods seen", {15'b0, ir_exp == 10}, 16'd1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); #1;
      check("R8 output gated by carrier", {15'b0, ch_out[0]}, {15'b0, carrier_out});
    end
    wr(4'd0, 16'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      check("R8 ungated when mode off", {15'b0, ch_out[0]}, 16'd1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_wrap();
    t_pwm();
    t_capture();
    t_ir();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule